// File: doc/BRIEF.md
# Multiplexed Bus Splitter with Address Hold and Data Steering

This block turns a processor's shared address/data pins into two separate system buses. During the address phase of a bus cycle the processor raises the address strobe (`ale`). While the strobe is high, the 20-bit address on the shared pins flows straight through to the address bus. When the strobe drops, the last value sampled on a clock edge with the strobe high is kept. That value stays on the address bus for the rest of the cycle, until the next strobe. The hold is built from 8-bit slices, and the top slice is trimmed to the 4 bits that remain.

The lower 16 shared lines also carry data. Two 8-bit steering slices connect these lines to a system data bus. An active-low enable gates both directions. A direction control chooses between a processor write (shared lines to system bus) and a processor read (system bus to shared lines). Each side is given as separate in, out and output-enable vectors, so the pads around the block can be tri-stated. Every pin is a plain level control. There is no valid/ready handshake, and the block never holds anything back: every output is a function of the present inputs and the held address.

Top module: `bfx_bus_split`

## Requirements
- R1: After reset is released with `ale` low, `addr_o` reads 0.
- R2: While `ale` is high, `addr_o` equals `mux_i` in the same cycle (transparent).
- R3: In the first cycle with `ale` low after a rising clock edge at which `ale` was high and reset was inactive, `addr_o` equals the `mux_i` value sampled at that edge.
- R4: While `ale` stays low, `addr_o` does not change, whatever `mux_i` does.
- R5: With `den_n` = 1, `cpu_d_oe` and `sys_d_oe` are all zeros.
- R6: With `den_n` = 0 and `dt_r` = 1 (transmit), `sys_d_oe` is all ones, `sys_d_o` equals `mux_i[15:0]`, and `cpu_d_oe` is all zeros.
- R7: With `den_n` = 0 and `dt_r` = 0 (receive), `cpu_d_oe` is all ones, `cpu_d_o` equals `sys_d_i`, and `sys_d_oe` is all zeros.
- R8: No bit position ever has `cpu_d_oe` and `sys_d_oe` both set.
- R9: Only `mux_i[15:0]` carries data. `mux_i[19:16]` reaches `addr_o` only and never reaches `sys_d_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address strobe; high means transparent |
| mux_i | input | 20 | Shared address/data lines from the processor |
| addr_o | output | 20 | Demultiplexed address bus |
| den_n | input | 1 | Active-low data path enable |
| dt_r | input | 1 | Direction: 1 = transmit to system bus, 0 = receive |
| cpu_d_o | output | 16 | Data driven back onto the shared lines |
| cpu_d_oe | output | 16 | Output enable for the shared-line side |
| sys_d_i | input | 16 | Data from the system data bus |
| sys_d_o | output | 16 | Data driven onto the system data bus |
| sys_d_oe | output | 16 | Output enable for the system bus side |

## Verification
The assertions check the following on every cycle:
- the address is held steady while the strobe stays low;
- the held value matches the last strobed input;
- both enables go quiet when the data path is disabled;
- the two sides of a bit are never enabled together.

The bench runs random mixes of strobe, enable and direction with directed corners. These show that the address is transparent during the strobe and the reset value appears. They also show that the data values follow the right source in each direction, and that the upper address bits never leak onto the data bus.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  parameter int ADDR_W  = 20;
  parameter int DATA_W  = 16;
  parameter int SLICE_W = 8;

  localparam int ADDR_SLICES = (ADDR_W + SLICE_W - 1) / SLICE_W;
  localparam int DATA_SLICES = DATA_W / SLICE_W;

  typedef enum logic {
    XFER_RX = 1'b0,
    XFER_TX = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/bfx_addr_slice.sv
module bfx_addr_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ale,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   hold_q <= '0;
    else if (ale) hold_q <= d_i;
  end

  assign q_o = ale ? d_i : hold_q;

  // R4
  addr_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !$past(ale)) |-> $stable(q_o));

  // R3
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(ale) && $past(rst_n)) |-> (q_o == $past(d_i)));
endmodule

// File: rtl/bfx_xcvr_slice.sv
module bfx_xcvr_slice
  import bfx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_n,
  input  xfer_dir_e    dir,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe
);
  logic drive_a, drive_b;

  always_comb begin
    drive_a = 1'b0;
    drive_b = 1'b0;
    if (!en_n) begin
      unique case (dir)
        XFER_TX: drive_b = 1'b1;
        XFER_RX: drive_a = 1'b1;
        default: ;
      endcase
    end
  end

  assign a_o  = b_i;
  assign b_o  = a_i;
  assign a_oe = {W{drive_a}};
  assign b_oe = {W{drive_b}};

  // R8
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe & b_oe) == '0);

  // R5
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (a_oe == '0 && b_oe == '0));
endmodule

// File: rtl/bfx_bus_split.sv
module bfx_bus_split
  import bfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [ADDR_W-1:0] mux_i,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              den_n,
  input  logic              dt_r,
  output logic [DATA_W-1:0] cpu_d_o,
  output logic [DATA_W-1:0] cpu_d_oe,
  input  logic [DATA_W-1:0] sys_d_i,
  output logic [DATA_W-1:0] sys_d_o,
  output logic [DATA_W-1:0] sys_d_oe
);
  xfer_dir_e dir;
  assign dir = dt_r ? XFER_TX : XFER_RX;

  for (genvar i = 0; i < ADDR_SLICES; i++) begin : g_addr
    localparam int LO = i * SLICE_W;
    localparam int HI = (LO + SLICE_W > ADDR_W) ? ADDR_W - 1 : LO + SLICE_W - 1;
    bfx_addr_slice #(.W(HI - LO + 1)) u_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .ale   (ale),
      .d_i   (mux_i[HI:LO]),
      .q_o   (addr_o[HI:LO])
    );
  end

  for (genvar j = 0; j < DATA_SLICES; j++) begin : g_data
    localparam int LO = j * SLICE_W;
    bfx_xcvr_slice #(.W(SLICE_W)) u_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .en_n  (den_n),
      .dir   (dir),
      .a_i   (mux_i[LO +: SLICE_W]),
      .b_i   (sys_d_i[LO +: SLICE_W]),
      .a_o   (cpu_d_o[LO +: SLICE_W]),
      .a_oe  (cpu_d_oe[LO +: SLICE_W]),
      .b_o   (sys_d_o[LO +: SLICE_W]),
      .b_oe  (sys_d_oe[LO +: SLICE_W])
    );
  end

  // R6
  tx_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && dt_r) |-> (sys_d_oe == '1 && sys_d_o == mux_i[DATA_W-1:0]));

  // R7
  rx_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && !dt_r) |-> (cpu_d_oe == '1 && cpu_d_o == sys_d_i));
endmodule

// File: tb/bfx_bus_split_bench.sv
module bfx_bus_split_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0;
  logic [19:0] mux_i = '0;
  logic [19:0] addr_o;
  logic        den_n = 1'b1;
  logic        dt_r = 1'b0;
  logic [15:0] cpu_d_o, cpu_d_oe, sys_d_i, sys_d_o, sys_d_oe;

  int total = 0;
  int bad = 0;
  logic [19:0] ref_q = '0;

  always #4 clk = ~clk;

  bfx_bus_split u_bfx_bus_split (
    .clk(clk), .rst_n(rst_n), .ale(ale), .mux_i(mux_i), .addr_o(addr_o),
    .den_n(den_n), .dt_r(dt_r), .cpu_d_o(cpu_d_o), .cpu_d_oe(cpu_d_oe),
    .sys_d_i(sys_d_i), .sys_d_o(sys_d_o), .sys_d_oe(sys_d_oe)
  );

  initial sys_d_i = '0;

  always @(posedge clk) begin
    if (!rst_n)   ref_q <= '0;
    else if (ale) ref_q <= mux_i;
  end

  function automatic logic [19:0] exp_addr(logic a, logic [19:0] m, logic [19:0] h);
    return a ? m : h;
  endfunction

  function automatic logic [15:0] exp_oe(logic en_n, logic want);
    return (!en_n && want) ? 16'hFFFF : 16'h0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [19:0] act,
                     input logic [19:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [19:0] ea;
    ea = exp_addr(ale, mux_i, ref_q);
    chk(addr_o == ea, ale ? "R2" : "R4", addr_o, ea);
    chk(cpu_d_oe == exp_oe(den_n, !dt_r), den_n ? "R5" : "R7",
        {4'h0, cpu_d_oe}, {4'h0, exp_oe(den_n, !dt_r)});
    chk(sys_d_oe == exp_oe(den_n, dt_r), den_n ? "R5" : "R6",
        {4'h0, sys_d_oe}, {4'h0, exp_oe(den_n, dt_r)});
    chk((cpu_d_oe & sys_d_oe) == 16'h0, "R8", {4'h0, cpu_d_oe & sys_d_oe}, 20'h0);
    if (!den_n && dt_r)
      chk(sys_d_o == mux_i[15:0], "R6", {4'h0, sys_d_o}, {4'h0, mux_i[15:0]});
    if (!den_n && !dt_r)
      chk(cpu_d_o == sys_d_i, "R7", {4'h0, cpu_d_o}, {4'h0, sys_d_i});
  endtask

  task automatic drive(input logic a, input logic [19:0] m, input logic en,
                       input logic d, input logic [15:0] s);
    @(negedge clk);
    ale = a; mux_i = m; den_n = en; dt_r = d; sys_d_i = s;
    #1;
    check_all();
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 20'h1, 20'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset value with strobe low
    chk(addr_o == 20'h0, "R1", addr_o, 20'h0);

    // R3: strobe an all-ones address, then drop and scramble input
    drive(1'b1, 20'hFFFFF, 1'b1, 1'b0, 16'h0);
    drive(1'b0, 20'h0A5A5, 1'b1, 1'b0, 16'h0);
    chk(addr_o == 20'hFFFFF, "R3", addr_o, 20'hFFFFF);
    // R4: input keeps moving with strobe low
    drive(1'b0, 20'h12345, 1'b1, 1'b0, 16'h0);
    chk(addr_o == 20'hFFFFF, "R4", addr_o, 20'hFFFFF);

    // R9: upper bits change, data bus shows only low 16 bits
    drive(1'b0, 20'hF0000, 1'b0, 1'b1, 16'h0);
    chk(sys_d_o == 16'h0000, "R9", {4'h0, sys_d_o}, 20'h0);
    drive(1'b0, 20'h0BEEF, 1'b0, 1'b1, 16'h0);
    chk(sys_d_o == 16'hBEEF, "R9", {4'h0, sys_d_o}, 20'h0BEEF);

    // R7: receive with distinct system data
    drive(1'b0, 20'h11111, 1'b0, 1'b0, 16'hC3C3);
    // R5: disabled, both directions
    drive(1'b0, 20'h22222, 1'b1, 1'b1, 16'h5555);
    drive(1'b0, 20'h33333, 1'b1, 1'b0, 16'hAAAA);

    // R3: two strobe cycles, the later one is kept
    drive(1'b1, 20'h00001, 1'b1, 1'b0, 16'h0);
    drive(1'b1, 20'h80000, 1'b1, 1'b0, 16'h0);
    drive(1'b0, 20'h7FFFF, 1'b1, 1'b0, 16'h0);
    chk(addr_o == 20'h80000, "R3", addr_o, 20'h80000);

    for (int k = 0; k < 600; k++) begin
      drive(($urandom % 10) < 3, 20'($urandom), 1'($urandom), 1'($urandom),
            16'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule